// File: doc/BRIEF.md
# I2C Master Register Front End with Transmit and Receive Queues

This block is the memory-mapped register side of an I2C master controller. A processor writes commands and data through a simple word-wide register bus. The block keeps a control word for a separate bit engine and queues outgoing words in a transmit FIFO. Incoming bytes are collected in a receive FIFO, and engine events are gathered into maskable interrupt flags. The bus-side bit timing and the pin drivers are outside this block. They sit behind a plain handshake: the engine takes queued words, hands back received bytes, acknowledges its start/stop/nack requests, and reports no-answer and arbitration-lost events.

A single data offset is shared by both queues. A write places a 9-bit word in the transmit queue, and bit 8 marks that word as an address command. A read removes the oldest received byte. A programmable receive target raises an interrupt once the expected number of bytes has arrived. Software drives a transfer by loading the address word, setting the start and master bits, and waiting on the interrupt flags. It clears each flag by writing a one to it.

Register reads are answered on `reg_rdata` in the cycle after `reg_rd`, and the value holds until the next read.

Top module: `i2c_master_regfront`

## Requirements
- R1: After reset, `reg_rdata`, `irq_o`, `ctrl_o`, `bus_reset_o`, `run_en_o` and `scl_release_o` are 0; the status word (offset 0x2C) reads 0x3 and the interrupt status (offset 0x20) reads 0x200 from the second cycle after reset.
- R2: The control word at 0x00 holds master (bit 3), start request (bit 2), stop request (bit 1) and nack request (bit 0). It reads back as written and drives `ctrl_o`. A 1 on `eng_done_i[k]` (k = 2, 1, 0) clears control bit k in the next cycle, unless that cycle writes the control word.
- R3: A write to 0x04 appends `reg_wdata[8:0]` to the transmit queue; `eng_tx_valid_o` is high while the queue is non-empty, `eng_tx_word_o` shows the oldest word (bit 8 = address command, bit 0 = read flag for address words) and holds steady until `eng_tx_ready_i` removes it.
- R4: A read from 0x04 returns the oldest received byte in bits 7:0 and removes it; a read with the receive queue empty returns 0 and changes nothing.
- R5: A write to 0x04 with the transmit queue full is ignored; a received byte arriving with the receive queue full is dropped and not counted.
- R6: Status bits: 12 = `eng_dev_busy_i`, 8 = `eng_bus_busy_i`, 3 = receive queue full, 2 = receive queue non-empty, 1 = transmit queue not full, 0 = transmit queue empty; other bits read 0.
- R7: Interrupt flag bits, shared by status (0x20), enable (0x24) and clear (0x28): bit 9 is set in every cycle the transmit queue is empty, bit 4 by the receive-count event, bit 2 by `eng_noans_i`, bit 1 by `eng_arblost_i`; flags are sticky.
- R8: Writing a 1 to a bit of 0x28 clears that flag, except when the same flag is set in that same cycle, in which case it stays set.
- R9: `irq_o` is the OR over flags ANDed with enable bits, registered: it reflects the flag and enable values of the previous cycle.
- R10: Offset 0x44 holds the receive target, and a write to it zeroes the received-byte count at 0x4C. Each accepted byte increments the count. Flag bit 4 is set on every accepted byte when the target is 0; otherwise it is set on the byte that brings the count equal to the target.
- R11: Writing 0x34 with bit 2 empties the transmit queue, with bit 1 empties the receive queue, and with bit 0 raises `bus_reset_o` for exactly one cycle.
- R12: Offset 0x50 bit 1 drives `run_en_o` (normal operation) and bit 0 drives `scl_release_o`; both read back.
- R13: Reserved and unmapped offsets (such as 0x08 and 0x30) read 0, and writes to them change no register, queue or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 4 | Control word to the bit engine |
| eng_done_i | input | 3 | Engine acknowledges start, stop, nack requests |
| eng_tx_valid_o | output | 1 | Transmit word available |
| eng_tx_ready_i | input | 1 | Engine takes the transmit word |
| eng_tx_word_o | output | 9 | Oldest transmit word |
| eng_rx_valid_i | input | 1 | Received byte strobe |
| eng_rx_byte_i | input | 8 | Received byte |
| eng_noans_i | input | 1 | No-answer event |
| eng_arblost_i | input | 1 | Arbitration-lost event |
| eng_dev_busy_i | input | 1 | Engine busy with a transfer |
| eng_bus_busy_i | input | 1 | Bus occupied |
| bus_reset_o | output | 1 | One-cycle forced bus reset request |
| run_en_o | output | 1 | Normal operation enable |
| scl_release_o | output | 1 | Release a forced clock-low condition |

## Verification
The bench builds the block with both queue depths set to 4. At that depth a handful of random writes or received bytes fills a queue, so dropped writes, full and empty status bits and pointer wrap-around all come up many times in a short run. The default address and data widths and an 8-bit receive count are kept, so the register map is exercised as specified. Directed cases then cover the clear-versus-set collision, the interrupt output latency and the receive-target counting.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

  // register byte offsets
  localparam logic [31:0] OFS_CTRL   = 32'h00;
  localparam logic [31:0] OFS_DATA   = 32'h04;
  localparam logic [31:0] OFS_ISTAT  = 32'h20;
  localparam logic [31:0] OFS_IEN    = 32'h24;
  localparam logic [31:0] OFS_ICLR   = 32'h28;
  localparam logic [31:0] OFS_STAT   = 32'h2C;
  localparam logic [31:0] OFS_RST    = 32'h34;
  localparam logic [31:0] OFS_RXTGT  = 32'h44;
  localparam logic [31:0] OFS_RXCNT  = 32'h4C;
  localparam logic [31:0] OFS_BUSCTL = 32'h50;

  // control word bits
  localparam int CB_MASTER = 3;
  localparam int CB_START  = 2;
  localparam int CB_STOP   = 1;
  localparam int CB_NACK   = 0;
  localparam int CTRL_W    = 4;
  localparam int REQ_W     = 3;

  // interrupt flag bits
  localparam int IB_TXEMPTY = 9;
  localparam int IB_RXHIT   = 4;
  localparam int IB_NOANS   = 2;
  localparam int IB_ARBLOST = 1;

  // status bits
  localparam int SB_DEVBUSY = 12;
  localparam int SB_BUSBUSY = 8;
  localparam int SB_RXFULL  = 3;
  localparam int SB_RXAVAIL = 2;
  localparam int SB_TXROOM  = 1;
  localparam int SB_TXEMPTY = 0;

  // reset register bits
  localparam int RB_TXFLUSH = 2;
  localparam int RB_RXFLUSH = 1;
  localparam int RB_BUSRST  = 0;

  // bus control bits
  localparam int BB_RUN     = 1;
  localparam int BB_SCLREL  = 0;

  // transmit word layout
  localparam int BYTE_W     = 8;
  localparam int TXW        = BYTE_W + 1;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_DATA, SEL_ISTAT, SEL_IEN, SEL_ICLR, SEL_STAT,
    SEL_RST, SEL_RXTGT, SEL_RXCNT, SEL_BUSCTL, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    case (a)
      OFS_CTRL:   return SEL_CTRL;
      OFS_DATA:   return SEL_DATA;
      OFS_ISTAT:  return SEL_ISTAT;
      OFS_IEN:    return SEL_IEN;
      OFS_ICLR:   return SEL_ICLR;
      OFS_STAT:   return SEL_STAT;
      OFS_RST:    return SEL_RST;
      OFS_RXTGT:  return SEL_RXTGT;
      OFS_RXCNT:  return SEL_RXCNT;
      OFS_BUSCTL: return SEL_BUSCTL;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/i2cfe_fifo.sv
// Show-ahead FIFO; DEPTH must be a power of two.
module i2cfe_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && $stable(wptr))); // R5

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> (empty && $stable(rptr))); // R4

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!empty && !pop && !flush) |=> (!empty && $stable(rdata))); // R3

endmodule

// File: rtl/i2cfe_irq.sv
module i2cfe_irq #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_i,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      en_o   <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= ((stat_o & ~clr_eff) | set_i) & MASK;
      if (en_wr) en_o <= en_wdata & MASK;
      irq_o  <= |(stat_o & en_o);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_eff & MASK) != '0) |=>
      ((stat_o & $past(set_i & clr_eff & MASK)) == $past(set_i & clr_eff & MASK))); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((clr_eff & ~set_i) != '0) |=> ((stat_o & $past(clr_eff & ~set_i)) == '0)); // R8

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(stat_o & en_o)))); // R9

endmodule

// File: rtl/i2cfe_rxcnt.sv
module i2cfe_rxcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_wr,
  input  logic [CW-1:0] tgt_wdata,
  input  logic          byte_in,
  output logic [CW-1:0] tgt_o,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_o + 1'b1;
  assign hit_o   = byte_in && ((tgt_o == '0) || (cnt_inc == tgt_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_o <= '0;
      cnt_o <= '0;
    end else if (tgt_wr) begin
      tgt_o <= tgt_wdata;
      cnt_o <= '0;
    end else if (byte_in) begin
      cnt_o <= cnt_inc;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (byte_in && !tgt_wr) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R10

  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |=> (cnt_o == '0)); // R10

endmodule

// File: rtl/i2c_master_regfront.sv
module i2c_master_regfront
  import i2cfe_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic [3:0]        ctrl_o,
  input  logic [2:0]        eng_done_i,
  output logic              eng_tx_valid_o,
  input  logic              eng_tx_ready_i,
  output logic [8:0]        eng_tx_word_o,
  input  logic              eng_rx_valid_i,
  input  logic [7:0]        eng_rx_byte_i,
  input  logic              eng_noans_i,
  input  logic              eng_arblost_i,
  input  logic              eng_dev_busy_i,
  input  logic              eng_bus_busy_i,
  output logic              bus_reset_o,
  output logic              run_en_o,
  output logic              scl_release_o
);
  localparam logic [DATA_W-1:0] IRQ_MASK =
    (DATA_W'(1) << IB_TXEMPTY) | (DATA_W'(1) << IB_RXHIT) |
    (DATA_W'(1) << IB_NOANS)   | (DATA_W'(1) << IB_ARBLOST);

  // ---------------- decode ----------------
  reg_sel_e    sel;
  logic [31:0] addr_ext;
  logic        wr_ctrl, wr_data, wr_ien, wr_iclr, wr_rst, wr_rxtgt, wr_busctl;
  logic        rd_data;

  assign addr_ext  = 32'(reg_addr);
  assign sel       = decode_addr(addr_ext);
  assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
  assign wr_data   = reg_wr && (sel == SEL_DATA);
  assign wr_ien    = reg_wr && (sel == SEL_IEN);
  assign wr_iclr   = reg_wr && (sel == SEL_ICLR);
  assign wr_rst    = reg_wr && (sel == SEL_RST);
  assign wr_rxtgt  = reg_wr && (sel == SEL_RXTGT);
  assign wr_busctl = reg_wr && (sel == SEL_BUSCTL);
  assign rd_data   = reg_rd && (sel == SEL_DATA);

  // ---------------- control word ----------------
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= reg_wdata[CTRL_W-1:0];
    end else begin
      ctrl_q <= ctrl_q & ~{1'b0, eng_done_i};
    end
  end
  assign ctrl_o = ctrl_q;

  // ---------------- bus control and reset pulse ----------------
  logic [1:0] busctl_q;
  logic       tx_flush, rx_flush;

  assign tx_flush = wr_rst && reg_wdata[RB_TXFLUSH];
  assign rx_flush = wr_rst && reg_wdata[RB_RXFLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      busctl_q    <= '0;
      bus_reset_o <= 1'b0;
    end else begin
      if (wr_busctl) busctl_q <= reg_wdata[1:0];
      bus_reset_o <= wr_rst && reg_wdata[RB_BUSRST];
    end
  end
  assign run_en_o      = busctl_q[BB_RUN];
  assign scl_release_o = busctl_q[BB_SCLREL];

  // ---------------- queues ----------------
  logic [TXW-1:0]    tx_head;
  logic [BYTE_W-1:0] rx_head;
  logic              tx_empty, tx_full, rx_empty, rx_full, rx_accept;

  i2cfe_fifo #(.DW(TXW), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush),
    .push  (wr_data),
    .wdata (reg_wdata[TXW-1:0]),
    .pop   (eng_tx_ready_i),
    .rdata (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  i2cfe_fifo #(.DW(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush),
    .push  (eng_rx_valid_i),
    .wdata (eng_rx_byte_i),
    .pop   (rd_data),
    .rdata (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign eng_tx_word_o  = tx_head;
  assign rx_accept      = eng_rx_valid_i && !rx_full && !rx_flush;

  // ---------------- receive count ----------------
  logic [CNT_W-1:0] rx_tgt, rx_cnt;
  logic             rx_hit;

  i2cfe_rxcnt #(.CW(CNT_W)) u_rxcnt (
    .clk       (clk),
    .rst       (rst),
    .tgt_wr    (wr_rxtgt),
    .tgt_wdata (reg_wdata[CNT_W-1:0]),
    .byte_in   (rx_accept),
    .tgt_o     (rx_tgt),
    .cnt_o     (rx_cnt),
    .hit_o     (rx_hit)
  );

  // ---------------- interrupts ----------------
  logic [DATA_W-1:0] irq_set, irq_stat, irq_en;

  always_comb begin
    irq_set             = '0;
    irq_set[IB_TXEMPTY] = tx_empty;
    irq_set[IB_RXHIT]   = rx_hit;
    irq_set[IB_NOANS]   = eng_noans_i;
    irq_set[IB_ARBLOST] = eng_arblost_i;
  end

  i2cfe_irq #(.W(DATA_W), .MASK(IRQ_MASK)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_i    (irq_set),
    .clr_wr   (wr_iclr),
    .clr_i    (reg_wdata),
    .en_wr    (wr_ien),
    .en_wdata (reg_wdata),
    .stat_o   (irq_stat),
    .en_o     (irq_en),
    .irq_o    (irq_o)
  );

  // ---------------- status and read mux ----------------
  logic [DATA_W-1:0] status_w, rd_mux;

  always_comb begin
    status_w             = '0;
    status_w[SB_DEVBUSY] = eng_dev_busy_i;
    status_w[SB_BUSBUSY] = eng_bus_busy_i;
    status_w[SB_RXFULL]  = rx_full;
    status_w[SB_RXAVAIL] = !rx_empty;
    status_w[SB_TXROOM]  = !tx_full;
    status_w[SB_TXEMPTY] = tx_empty;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:   rd_mux = DATA_W'(ctrl_q);
      SEL_DATA:   rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      SEL_ISTAT:  rd_mux = irq_stat;
      SEL_IEN:    rd_mux = irq_en;
      SEL_STAT:   rd_mux = status_w;
      SEL_RXTGT:  rd_mux = DATA_W'(rx_tgt);
      SEL_RXCNT:  rd_mux = DATA_W'(rx_cnt);
      SEL_BUSCTL: rd_mux = DATA_W'(busctl_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // ---------------- checks ----------------
  AST_REQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!wr_ctrl && (eng_done_i != '0)) |=> ((ctrl_o[2:0] & $past(eng_done_i)) == '0)); // R2

  AST_BUSRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_reset_o |-> $past(wr_rst && reg_wdata[RB_BUSRST])); // R11

  AST_TX_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_valid_o && !eng_tx_ready_i && !tx_flush) |=>
      (eng_tx_valid_o && $stable(eng_tx_word_o))); // R3

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (sel == SEL_NONE) && !eng_tx_ready_i && (eng_done_i == '0)) |=>
      ($stable(ctrl_o) && $stable(eng_tx_valid_o) && $stable(run_en_o))); // R13

endmodule

// File: tb/i2c_master_regfront_bench.sv
module i2c_master_regfront_bench;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_o;
  logic [3:0]    ctrl_o;
  logic [2:0]    eng_done_i = '0;
  logic          eng_tx_valid_o;
  logic          eng_tx_ready_i = 0;
  logic [8:0]    eng_tx_word_o;
  logic          eng_rx_valid_i = 0;
  logic [7:0]    eng_rx_byte_i = '0;
  logic          eng_noans_i = 0, eng_arblost_i = 0;
  logic          eng_dev_busy_i = 0, eng_bus_busy_i = 0;
  logic          bus_reset_o, run_en_o, scl_release_o;

  int nchk = 0;
  int nerr = 0;
  logic [8:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  i2c_master_regfront #(.ADDR_W(AW), .DATA_W(DW), .TX_DEPTH(QD), .RX_DEPTH(QD), .CNT_W(8))
  u_i2c_master_regfront (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .ctrl_o(ctrl_o),
    .eng_done_i(eng_done_i), .eng_tx_valid_o(eng_tx_valid_o), .eng_tx_ready_i(eng_tx_ready_i),
    .eng_tx_word_o(eng_tx_word_o), .eng_rx_valid_i(eng_rx_valid_i), .eng_rx_byte_i(eng_rx_byte_i),
    .eng_noans_i(eng_noans_i), .eng_arblost_i(eng_arblost_i), .eng_dev_busy_i(eng_dev_busy_i),
    .eng_bus_busy_i(eng_bus_busy_i), .bus_reset_o(bus_reset_o), .run_en_o(run_en_o),
    .scl_release_o(scl_release_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input int txn, input int rxn, input bit db, input bit bb);
    logic [31:0] s = '0;
    s[12] = db; s[8] = bb;
    s[3] = (rxn == QD); s[2] = (rxn != 0);
    s[1] = (txn != QD); s[0] = (txn == 0);
    return s;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a[AW-1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a[AW-1:0];
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic tx_take();
    eng_tx_ready_i = 1;
    @(negedge clk);
    eng_tx_ready_i = 0;
  endtask

  task automatic rx_give(input logic [7:0] b);
    eng_rx_valid_i = 1; eng_rx_byte_i = b;
    @(negedge clk);
    eng_rx_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [8:0]  w;
    logic [7:0]  b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 ctrl", {28'd0, ctrl_o}, 0);
    chk("R1 outs", {29'd0, bus_reset_o, run_en_o, scl_release_o}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    rd(8'h2C, d); chk("R1 status", d, 32'h3);
    rd(8'h20, d); chk("R1 istat", d, 32'h200);

    // R2 control word and engine acks
    wr(8'h00, 32'hF); rd(8'h00, d); chk("R2 readback", d, 32'hF);
    chk("R2 ctrl_o", {28'd0, ctrl_o}, 32'hF);
    eng_done_i = 3'b100; @(negedge clk); eng_done_i = '0;
    rd(8'h00, d); chk("R2 start ack", d, 32'hB);
    eng_done_i = 3'b011; @(negedge clk); eng_done_i = '0;
    chk("R2 stop nack ack", {28'd0, ctrl_o}, 32'h8);
    eng_done_i = 3'b100; reg_wr = 1; reg_addr = 7'h00; reg_wdata = 32'hC;
    @(negedge clk); eng_done_i = '0; reg_wr = 0;
    chk("R2 write beats ack", {28'd0, ctrl_o}, 32'hC);

    // R3 R5 R6 random transmit traffic
    for (int i = 0; i < 120; i++) begin
      if (($urandom % 3) != 0) begin
        w = 9'($urandom);
        wr(8'h04, {23'd0, w});
        if (txq.size() < QD) txq.push_back(w);
      end else if (txq.size() > 0) begin
        chk("R3 tx valid", {31'd0, eng_tx_valid_o}, 1);
        chk("R3 tx word", {23'd0, eng_tx_word_o}, {23'd0, txq[0]});
        void'(txq.pop_front());
        tx_take();
      end else begin
        chk("R3 tx idle", {31'd0, eng_tx_valid_o}, 0);
      end
      if ((i % 5) == 0) begin
        rd(8'h2C, d); chk("R5 R6 tx status", d, exp_status(txq.size(), 0, 0, 0));
      end
    end
    // directed: address command word, overfill
    wr(8'h34, 32'h4); txq.delete();
    wr(8'h04, 32'h1A5);
    chk("R3 address word", {23'd0, eng_tx_word_o}, 32'h1A5);
    for (int i = 0; i < QD; i++) wr(8'h04, i + 1);
    rd(8'h2C, d); chk("R5 tx full", d, exp_status(QD, 0, 0, 0));
    chk("R5 head after overfill", {23'd0, eng_tx_word_o}, 32'h1A5);
    for (int i = 0; i < QD; i++) tx_take();
    chk("R5 dropped write", {31'd0, eng_tx_valid_o}, 0);

    // R4 R5 random receive traffic
    for (int i = 0; i < 120; i++) begin
      if (($urandom % 2) != 0) begin
        b = 8'($urandom);
        rx_give(b);
        if (rxq.size() < QD) rxq.push_back(b);
      end else begin
        rd(8'h04, d);
        if (rxq.size() > 0) begin
          chk("R4 rx byte", d, {24'd0, rxq[0]});
          void'(rxq.pop_front());
        end else chk("R4 empty read", d, 0);
      end
      if ((i % 6) == 0) begin
        rd(8'h2C, d); chk("R4 R6 rx status", d, exp_status(0, rxq.size(), 0, 0));
      end
    end
    wr(8'h34, 32'h2); rxq.delete();
    rd(8'h04, d); chk("R4 read after drain", d, 0);
    rd(8'h2C, d); chk("R4 empty read no effect", d, exp_status(0, 0, 0, 0));

    // R6 busy inputs
    eng_dev_busy_i = 1; eng_bus_busy_i = 1;
    rd(8'h2C, d); chk("R6 busy bits", d, exp_status(0, 0, 1, 1));
    eng_dev_busy_i = 0; eng_bus_busy_i = 0;

    // R7 R8 R9 interrupts
    wr(8'h28, 32'h16);
    wr(8'h24, 32'h4);
    chk("R9 irq idle", {31'd0, irq_o}, 0);
    eng_noans_i = 1; @(negedge clk); eng_noans_i = 0;
    chk("R9 irq latency", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R9 irq raised", {31'd0, irq_o}, 1);
    rd(8'h20, d); chk("R7 noans flag", d & 32'h16, 32'h4);
    eng_noans_i = 1; reg_wr = 1; reg_addr = 7'h28; reg_wdata = 32'h4;
    @(negedge clk); eng_noans_i = 0; reg_wr = 0;
    rd(8'h20, d); chk("R8 set wins", d & 32'h4, 32'h4);
    wr(8'h28, 32'h4);
    rd(8'h20, d); chk("R8 clear", d & 32'h16, 0);
    @(negedge clk);
    chk("R9 irq dropped", {31'd0, irq_o}, 0);
    eng_arblost_i = 1; @(negedge clk); eng_arblost_i = 0;
    rd(8'h20, d); chk("R7 arblost flag", d, 32'h202);
    chk("R9 masked", {31'd0, irq_o}, 0);
    wr(8'h28, 32'h202);
    rd(8'h20, d); chk("R7 R8 txempty level wins", d, 32'h200);
    wr(8'h04, 32'h55); wr(8'h28, 32'h200);
    rd(8'h20, d); chk("R7 txempty cleared", d, 0);
    tx_take(); @(negedge clk);
    rd(8'h20, d); chk("R7 txempty after drain", d, 32'h200);
    wr(8'h24, 32'h200); @(negedge clk);
    chk("R9 txempty irq", {31'd0, irq_o}, 1);
    wr(8'h24, 32'h0);

    // R10 receive count
    wr(8'h44, 32'h0);
    rx_give(8'h11);
    rd(8'h20, d); chk("R10 target zero", d & 32'h10, 32'h10);
    wr(8'h28, 32'h10); wr(8'h34, 32'h2);
    wr(8'h44, 32'h3);
    rd(8'h4C, d); chk("R10 count zeroed", d, 0);
    rx_give(8'h21); rx_give(8'h22);
    rd(8'h20, d); chk("R10 below target", d & 32'h10, 0);
    rd(8'h4C, d); chk("R10 count", d, 2);
    rx_give(8'h23);
    rd(8'h20, d); chk("R10 target hit", d & 32'h10, 32'h10);
    rd(8'h44, d); chk("R10 target readback", d, 3);
    rx_give(8'h24); rx_give(8'h25);
    rd(8'h4C, d); chk("R5 full rx not counted", d, 4);
    rd(8'h04, d); chk("R10 rx order", d, 32'h21);

    // R11 reset register
    wr(8'h04, 32'h7);
    wr(8'h34, 32'h6);
    rd(8'h2C, d); chk("R11 flush both", d, exp_status(0, 0, 0, 0));
    wr(8'h34, 32'h1);
    chk("R11 pulse high", {31'd0, bus_reset_o}, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'd0, bus_reset_o}, 0);

    // R12 bus control
    wr(8'h50, 32'h3);
    chk("R12 outputs", {30'd0, run_en_o, scl_release_o}, 32'h3);
    rd(8'h50, d); chk("R12 readback", d, 32'h3);
    wr(8'h50, 32'h2);
    chk("R12 run only", {30'd0, run_en_o, scl_release_o}, 32'h2);

    // R13 reserved offsets
    wr(8'h00, 32'h8);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R13 reserved 08", d, 0);
    rd(8'h30, d); chk("R13 reserved 30", d, 0);
    chk("R13 ctrl kept", {28'd0, ctrl_o}, 32'h8);
    chk("R13 bus ctl kept", {30'd0, run_en_o, scl_release_o}, 32'h2);
    rd(8'h2C, d); chk("R13 queues kept", d, exp_status(0, 0, 0, 0));

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule